// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address for a synchronous burst access to a memory. A burst begins when either of two independent active-low load strobes is sampled low on a rising clock edge. On that edge the external start address is captured, and the internal burst count restarts at zero.

After the load, each rising edge on which the active-low advance input is low moves the burst one step. Only the low `CNT_W` address bits (two by default) take part in the burst. The upper bits stay as they were loaded.

A static order-select input picks the step order:
- **Linear order** counts the low bits upward, modulo the burst length, starting from the loaded value.
- **Interleaved order** XORs the loaded low bits with the internal count.

Both outputs are registered. `word_addr` carries the current address. `burst_start` marks the cycle that follows a load.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high on a rising edge, `word_addr` becomes 0 and `burst_start` becomes 0.
- R2: If `load_a_n` or `load_b_n` (or both) is sampled low, then one cycle later `word_addr` equals the sampled `start_addr`.
- R3: `burst_start` is 1 in exactly the cycle after an edge on which a load strobe was sampled low. In every other cycle it is 0.
- R4: An advance (`advance_n` sampled low, with no strobe low) changes only bits [CNT_W-1:0] of `word_addr`. Bits [ADDR_W-1:CNT_W] keep their value.
- R5: With `order_sel` = 0 (linear), after k advances since the last load, `word_addr[1:0]` equals (loaded low bits + k) mod 4.
- R6: With `order_sel` = 1 (interleaved), after k advances since the last load, `word_addr[1:0]` equals the loaded low bits XOR (k mod 4).
- R7: When both strobes and `advance_n` are high on an edge, `word_addr` keeps its value.
- R8: When a strobe and `advance_n` are low on the same edge, the load takes effect and the count restarts. The next advance therefore yields step k = 1 from the newly loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | ADDR_W | External burst start address |
| load_a_n | input | 1 | First active-low load strobe |
| load_b_n | input | 1 | Second active-low load strobe |
| advance_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| word_addr | output | ADDR_W | Registered burst word address |
| burst_start | output | 1 | High in the cycle after a load |

## Verification
The bench sweeps all four low start values under both orders, through each strobe alone and through both strobes together. It follows each load with five advances, so the modulo wrap past the fourth step is covered. Start values 1 and 3 separate linear from interleaved order, because for those values the two orders produce different sequences. Each upper-bit pattern is a non-trivial constant, so any leakage of the count into the upper bits shows up. Idle cycles check that the address holds. Loads issued together with an advance check that the load takes priority and that the count restarts.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bag_burst_cnt.sv
module bag_burst_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_d
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R8: a load restarts the count even when an advance is present
  p_cnt_restart_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0));
  // R4: each advance moves the count by exactly one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/bag_addr_reg.sv
module bag_addr_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= start_addr;
  end

  // R7: the base only changes on a load
  p_base_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base_q));
endmodule

// File: rtl/bag_order.sv
module bag_order
  import bag_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  burst_order_e     order,
  input  logic [CNT_W-1:0] base_lo,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] addr_lo
);
  always_comb begin
    case (order)
      ORD_INTERLEAVE: addr_lo = base_lo ^ cnt;
      default:        addr_lo = base_lo + cnt;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              advance_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_start
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic              load;
  logic              step;
  logic [CNT_W-1:0]  cnt_d;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  lo_d;
  logic [ADDR_W-1:0] addr_d;
  burst_order_e      order;

  assign load  = ~load_a_n | ~load_b_n;
  assign step  = ~advance_n;
  assign order = burst_order_e'(order_sel);

  bag_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr), .base_q(base_q)
  );

  bag_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .step(step), .cnt_d(cnt_d)
  );

  bag_order #(.CNT_W(CNT_W)) u_ord (
    .order(order), .base_lo(base_q[CNT_W-1:0]), .cnt(cnt_d), .addr_lo(lo_d)
  );

  always_comb begin
    if (load)      addr_d = start_addr;
    else if (step) addr_d = {base_q[ADDR_W-1:CNT_W], lo_d};
    else           addr_d = word_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr   <= '0;
      burst_start <= 1'b0;
    end else begin
      word_addr   <= addr_d;
      burst_start <= load;
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_a_n || !load_b_n) |=> (word_addr == $past(start_addr)));
  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (load_a_n && load_b_n) |=> !burst_start);
  p_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (load_a_n && load_b_n) |=> (word_addr[ADDR_W-1:CNT_W] == $past(word_addr[ADDR_W-1:CNT_W])));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (load_a_n && load_b_n && advance_n) |=> $stable(word_addr));
  p_hi_w_ok: assert property (@(posedge clk) HI_W > 0);
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic          load_a_n = 1'b1;
  logic          load_b_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] word_addr;
  logic          burst_start;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) dut_i (
    .clk(clk), .rst(rst), .start_addr(start_addr), .load_a_n(load_a_n),
    .load_b_n(load_b_n), .advance_n(advance_n), .order_sel(order_sel),
    .word_addr(word_addr), .burst_start(burst_start)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s, input int k, input logic mode);
    logic [1:0] lo;
    lo = mode ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  initial begin
    #700000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    check("R1 reset address", word_addr, '0);
    check("R1 reset start flag", {19'd0, burst_start}, '0);
    rst = 1'b0;
    for (int mode = 0; mode < 2; mode++) begin
      for (int sel = 0; sel < 3; sel++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic [AW-1:0] s;
          s = {18'h2A5C3 ^ 18'(sel * 18'h1111 + lo * 18'h0357), 2'(lo)};
          order_sel  = 1'(mode);
          start_addr = s;
          load_a_n   = (sel == 1);
          load_b_n   = (sel == 0);
          tick();
          load_a_n = 1'b1; load_b_n = 1'b1;
          start_addr = ~s;
          check("R2 load", word_addr, s);
          check("R3 start flag after load", {19'd0, burst_start}, 20'd1);
          for (int k = 1; k <= 5; k++) begin
            advance_n = 1'b0;
            tick();
            check(mode ? "R6 interleaved step" : "R5 linear step", word_addr, expect_addr(s, k, 1'(mode)));
            check("R4 upper bits", {word_addr[AW-1:2], 2'b00}, {s[AW-1:2], 2'b00});
            check("R3 start flag low", {19'd0, burst_start}, '0);
          end
          advance_n = 1'b1;
          tick(); tick();
          check("R7 hold", word_addr, expect_addr(s, 5, 1'(mode)));
          // R8: load together with advance
          start_addr = s ^ 20'h80003;
          load_b_n = 1'b0; advance_n = 1'b0;
          tick();
          load_b_n = 1'b1;
          check("R8 load wins", word_addr, s ^ 20'h80003);
          tick();
          check("R8 count restart", word_addr, expect_addr(s ^ 20'h80003, 1, 1'(mode)));
          advance_n = 1'b1;
          tick();
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule